// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block derives the serial clock of an I2C master from the system clock. It has two stages. The first is a programmable divider that emits a one-cycle enable strobe, the module tick, once every (prescale + 1) input clocks. The second is a phase sequencer that counts those ticks to form a low phase and then a high phase. Each phase lasts its programmed count plus a fixed offset, and that offset depends on the prescale setting.

The clock runs only while the block is both enabled and configured as bus master. Otherwise the open-drain pull-down is released and the line floats high. The prescale, low and high settings are captured when a period begins, so writes that arrive mid-period take effect at the next period. A combinational flag warns when the prescale setting puts the module tick rate outside the allowed 6.7 to 13.3 MHz band for the input clock frequency given as a parameter.

Top module: `scl_clkgen`

## Requirements
- R1: While rst_ni is low, scl_o is 1, scl_oe_o is 0 and tick_o is 0.
- R2: While the clock runs, tick_o is high for exactly one cycle out of every (psc + 1) input clock cycles, where psc is the captured prescale value.
- R3: The per-phase offset d is 7 when psc is 0, 6 when psc is 1 and 5 when psc is 2 or more.
- R4: Each low phase (scl_o = 0) lasts (low_cnt + d) * (psc + 1) input clock cycles.
- R5: Each high phase (scl_o = 1) inside a running clock lasts (high_cnt + d) * (psc + 1) input clock cycles.
- R6: On the first clock edge at which en_i and master_i are both sampled high, the idle clock enters the low phase: scl_o goes to 0.
- R7: On the first clock edge at which en_i or master_i is sampled low, the block goes idle. scl_o is then 1 and scl_oe_o is 0, no tick is issued while idle, and the next start begins with a fresh low phase.
- R8: scl_oe_o (1 = pull the line low) is high exactly when scl_o is 0.
- R9: psc_i, low_cnt_i and high_cnt_i are captured only when a period starts (at enable and at each high-to-low transition). A change during a period leaves the current low and high phases unchanged and applies from the next period.
- R10: range_err_o is 1 exactly when CLK_HZ / (psc_i + 1) is below 6.7 MHz or above 13.3 MHz. It follows psc_i combinationally, whether or not the clock runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock generation enable |
| master_i | input | 1 | Block is configured as bus master |
| psc_i | input | 8 | Prescale value; tick every psc_i + 1 clocks |
| low_cnt_i | input | 16 | Low phase count, offset d added |
| high_cnt_i | input | 16 | High phase count, offset d added |
| scl_oe_o | output | 1 | Open-drain drive enable, 1 pulls SCL low |
| scl_o | output | 1 | Generated SCL level |
| tick_o | output | 1 | Prescaled module tick strobe |
| range_err_o | output | 1 | Module tick rate outside 6.7 to 13.3 MHz |

## Verification
The bench builds the block with its default 100 MHz input clock. With that clock, prescale values 7 through 13 are legal and 6 and 14 are the nearest values on either side that must raise the range flag. Small phase counts, combined with prescale values 0, 1, 2 and 10, bring all three offset values and multi-cycle ticks within a few hundred cycles. Exact phase lengths can therefore be measured, including a mid-period reconfiguration.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // fixed per-phase extension, set by the prescale value
  function automatic logic [2:0] phase_offset(input int unsigned psc);
    if (psc == 0)      return 3'd7;
    else if (psc == 1) return 3'd6;
    else               return 3'd5;
  endfunction

endpackage

// File: rtl/scl_psc_tick.sv
module scl_psc_tick #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_i);
  assign tick_o = active_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (wrap)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // R2
  psc_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> cnt_q <= div_i);

  // R2
  psc_idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> cnt_q == '0);

endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import scl_gen_pkg::*;
#(
  parameter int unsigned PSC_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] low_i,
  input  logic [CNT_W-1:0] high_i,
  output phase_e           phase_o,
  output logic [PSC_W-1:0] psc_q_o
);

  localparam int unsigned LIM_W = CNT_W + 1;

  phase_e           state_q, state_d;
  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] low_q, high_q;
  logic [2:0]       offs;
  logic [LIM_W-1:0] low_lim, high_lim;
  logic             load;

  assign offs     = phase_offset(int'(psc_q));
  assign low_lim  = {1'b0, low_q}  + LIM_W'(offs) - 1'b1;
  assign high_lim = {1'b0, high_q} + LIM_W'(offs) - 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    if (!run_i) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PH_IDLE: begin
          state_d = PH_LOW;
          cnt_d   = '0;
          load    = 1'b1;
        end
        PH_LOW: if (tick_i) begin
          if (cnt_q == low_lim) begin
            state_d = PH_HIGH;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_HIGH: if (tick_i) begin
          if (cnt_q == high_lim) begin
            state_d = PH_LOW;
            cnt_d   = '0;
            load    = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      psc_q   <= '0;
      low_q   <= '0;
      high_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (load) begin
        psc_q  <= psc_i;
        low_q  <= low_i;
        high_q <= high_i;
      end
    end
  end

  assign phase_o = state_q;
  assign psc_q_o = psc_q;

  // R7
  stop_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> state_q == PH_IDLE);

  // R6
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_IDLE && run_i) |=> state_q == PH_LOW);

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_LOW) |=> ($stable(low_q) && $stable(high_q) && $stable(psc_q)));

  // R4
  low_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_LOW) |-> cnt_q <= low_lim);

  // R5
  high_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_HIGH) |-> cnt_q <= high_lim);

endmodule

// File: rtl/scl_range_chk.sv
module scl_range_chk #(
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned MIN_HZ = 6_700_000,
  parameter int unsigned MAX_HZ = 13_300_000
) (
  input  logic [PSC_W-1:0] psc_i,
  output logic             err_o
);

  logic [63:0] div, lo_bound, hi_bound;

  // rate = CLK_HZ / div; compare by cross-multiplying to avoid a divider
  always_comb begin
    div      = 64'(psc_i) + 64'd1;
    lo_bound = 64'(MIN_HZ) * div;
    hi_bound = 64'(MAX_HZ) * div;
    err_o    = (64'(CLK_HZ) < lo_bound) || (64'(CLK_HZ) > hi_bound);
  end

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_gen_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned MIN_HZ = 6_700_000,
  parameter int unsigned MAX_HZ = 13_300_000,
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             master_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  output logic             scl_oe_o,
  output logic             scl_o,
  output logic             tick_o,
  output logic             range_err_o
);

  logic             run;
  logic             tick;
  phase_e           phase;
  logic [PSC_W-1:0] psc_q;

  assign run = en_i & master_i;

  scl_phase_ctl #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .tick_i  (tick),
    .psc_i   (psc_i),
    .low_i   (low_cnt_i),
    .high_i  (high_cnt_i),
    .phase_o (phase),
    .psc_q_o (psc_q)
  );

  scl_psc_tick #(.PSC_W(PSC_W)) u_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (phase != PH_IDLE),
    .div_i    (psc_q),
    .tick_o   (tick)
  );

  scl_range_chk #(
    .PSC_W(PSC_W), .CLK_HZ(CLK_HZ), .MIN_HZ(MIN_HZ), .MAX_HZ(MAX_HZ)
  ) u_range (
    .psc_i (psc_i),
    .err_o (range_err_o)
  );

  assign scl_o    = (phase != PH_LOW);
  assign scl_oe_o = (phase == PH_LOW);
  assign tick_o   = tick;

  // R7
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (scl_o && !scl_oe_o && !tick_o));

endmodule

// File: tb/scl_clkgen_test.sv
module scl_clkgen_test;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        master_i = 1'b0;
  logic [7:0]  psc_i = '0;
  logic [15:0] low_cnt_i = '0;
  logic [15:0] high_cnt_i = '0;
  logic        scl_oe_o, scl_o, tick_o, range_err_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  scl_clkgen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .master_i(master_i),
    .psc_i(psc_i), .low_cnt_i(low_cnt_i), .high_cnt_i(high_cnt_i),
    .scl_oe_o(scl_oe_o), .scl_o(scl_o), .tick_o(tick_o), .range_err_o(range_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_d(input int p);
    if (p == 0) return 7;
    if (p == 1) return 6;
    return 5;
  endfunction

  task automatic restart(input int p, input int lo, input int hi);
    @(negedge clk_i);
    en_i = 1'b0;
    master_i = 1'b1;
    psc_i = 8'(p);
    low_cnt_i = 16'(lo);
    high_cnt_i = 16'(hi);
    @(negedge clk_i);
    en_i = 1'b1;
  endtask

  // measures one full period starting at the next high-to-low transition
  task automatic measure(output int lo, output int hi, output int bad_oe);
    lo = 0; hi = 0; bad_oe = 0;
    @(negedge clk_i);
    while (scl_o == 1'b0) @(negedge clk_i);
    while (scl_o == 1'b1) @(negedge clk_i);
    while (scl_o == 1'b0) begin
      if (scl_oe_o != 1'b1) bad_oe++;
      lo++;
      @(negedge clk_i);
    end
    while (scl_o == 1'b1) begin
      if (scl_oe_o != 1'b0) bad_oe++;
      hi++;
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(scl_o == 1'b1, "R1 scl_o", int'(scl_o), 1);
    chk(scl_oe_o == 1'b0, "R1 scl_oe_o", int'(scl_oe_o), 0);
    chk(tick_o == 1'b0, "R1 tick_o", int'(tick_o), 0);
  endtask

  task automatic t_phase(input int p, input int lo, input int hi);
    int mlo, mhi, bad;
    int d;
    d = exp_d(p);
    restart(p, lo, hi);
    measure(mlo, mhi, bad);
    // R3 offset folded into both phase lengths
    chk(mlo == (lo + d) * (p + 1), "R4/R3 low phase", mlo, (lo + d) * (p + 1));
    chk(mhi == (hi + d) * (p + 1), "R5/R3 high phase", mhi, (hi + d) * (p + 1));
    chk(bad == 0, "R8 oe vs scl", bad, 0);
  endtask

  task automatic t_tick;
    int n;
    int wide;
    restart(3, 2, 2);
    @(negedge clk_i);
    while (tick_o == 1'b0) @(negedge clk_i);
    n = 0;
    wide = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (n == 1 && tick_o) wide = 1;
    end while (tick_o == 1'b0);
    chk(n == 4, "R2 tick spacing", n, 4);
    chk(wide == 0, "R2 tick width", wide, 0);
  endtask

  task automatic t_start;
    @(negedge clk_i);
    en_i = 1'b0;
    psc_i = 8'd0; low_cnt_i = 16'd1; high_cnt_i = 16'd1;
    repeat (3) @(negedge clk_i);
    chk(scl_o == 1'b1, "R6 idle before start", int'(scl_o), 1);
    en_i = 1'b1;
    @(negedge clk_i);
    chk(scl_o == 1'b0, "R6 low after start", int'(scl_o), 0);
    chk(scl_oe_o == 1'b1, "R6 oe after start", int'(scl_oe_o), 1);
  endtask

  task automatic t_stop(input bit use_master);
    int ticks;
    restart(2, 3, 3);
    repeat (13) @(negedge clk_i);
    if (use_master) master_i = 1'b0;
    else en_i = 1'b0;
    @(negedge clk_i);
    chk(scl_o == 1'b1 && scl_oe_o == 1'b0, use_master ? "R7 master off release" : "R7 disable release",
        int'({scl_o, scl_oe_o}), 2);
    ticks = 0;
    repeat (20) begin
      if (tick_o) ticks++;
      @(negedge clk_i);
    end
    chk(ticks == 0, "R7 no ticks while idle", ticks, 0);
    chk(scl_o == 1'b1, "R7 still high", int'(scl_o), 1);
    master_i = 1'b1;
    en_i = 1'b1;
    @(negedge clk_i);
    chk(scl_o == 1'b0, "R7 restart with low", int'(scl_o), 0);
  endtask

  task automatic t_midchange;
    int lo, hi, lo2;
    restart(0, 2, 1);
    @(negedge clk_i);
    low_cnt_i = 16'd10;
    high_cnt_i = 16'd4;
    lo = 0;
    while (scl_o == 1'b0) begin lo++; @(negedge clk_i); end
    hi = 0;
    while (scl_o == 1'b1) begin hi++; @(negedge clk_i); end
    lo2 = 0;
    while (scl_o == 1'b0) begin lo2++; @(negedge clk_i); end
    chk(lo == 9, "R9 current low kept", lo, 9);
    chk(hi == 8, "R9 current high kept", hi, 8);
    chk(lo2 == 17, "R9 next low uses new value", lo2, 17);
  endtask

  task automatic t_range;
    int vals[6] = '{0, 6, 7, 13, 14, 255};
    int expv[6] = '{1, 1, 0, 0, 1, 1};
    @(negedge clk_i);
    en_i = 1'b0;
    foreach (vals[i]) begin
      psc_i = 8'(vals[i]);
      #1;
      chk(range_err_o == expv[i][0], "R10 range flag", int'(range_err_o), expv[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk_i);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_phase(0, 1, 3);
    t_phase(1, 1, 3);
    t_phase(2, 1, 3);
    t_phase(10, 20, 5);
    t_tick();
    t_start();
    t_stop(1'b0);
    t_stop(1'b1);
    t_midchange();
    t_range();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule